// File: doc/BRIEF.md
# Variable-Rate Scrolling Text Ticker

This block drives a row of eight seven-segment digits so that the word HELLO, followed by three blank positions, scrolls from right to left. The digits are held in a chain of segment registers that all move one place on each shift; digit 0 is the rightmost position and the chain carries each character leftward. After reset, a loader steps through the eight characters of the message and pushes one into the rightmost digit on each shift. Once the eighth character is in, the loader closes the chain into a ring, so whatever leaves the leftmost digit re-enters on the right, and the text repeats forever.

Every register runs on one system clock. A free-running tick counter produces a one-cycle shift enable, and its period is a power-of-two multiple of a base count (a quarter second at 50 MHz). Two active-low pushbuttons each pass through a two-stage synchronizer into a small rate controller. One press of the speed-up key halves the interval and one press of the slow-down key doubles it, within five levels from a quarter second to four seconds. A held key acts only once. Both keys together change nothing. There is no data stream at the edge of the block: the key inputs and the segment outputs are plain level pins, so no valid/ready handshake or back-pressure applies.

Top module: `ticker_scroll`

## Requirements
- R1: While rst_n is low at a rising clock edge (synchronous, active-low), every digit goes blank (7'h7F), the rate returns to the middle level (an interval of 4*CYCLES_QUARTER cycles) and the loader restarts at the first character.
- R2: The digits change only on a shift tick. At the reset level the first shift comes 4*CYCLES_QUARTER cycles after reset is released, and later shifts follow at that same spacing.
- R3: On each of the first eight shifts, digit k+1 takes the old value of digit k, and digit 0 takes the next message character in the order H, E, L, L, O, blank, blank, blank. Digit k sits at digits[7k+6:7k]. Segments are active-low, with bit 0 = segment a through bit 6 = segment g: H=7'h09, E=7'h06, L=7'h47, O=7'h40, blank=7'h7F.
- R4: From the ninth shift onward, digit 0 takes the old value of digit 7, so after n shifts the display shows the message rotated by n positions, indefinitely.
- R5: Each press of key_fast_n halves the shift interval, down to a floor of CYCLES_QUARTER cycles. A press at the floor changes nothing.
- R6: Each press of key_slow_n doubles the shift interval, up to a ceiling of 16*CYCLES_QUARTER cycles. A press at the ceiling changes nothing.
- R7: A press acts exactly once, however long the key is held. No further step is taken until both keys have been released.
- R8: If both keys are seen pressed together, the rate is left unchanged.
- R9: Keys pass through two synchronizer flip-flops, and a rate change restarts the interval count. If a key falls just after a shift and the old interval is longer than three cycles, the next shift comes 3 + (new interval) cycles after that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for every register |
| rst_n | input | 1 | Synchronous active-low reset |
| key_fast_n | input | 1 | Asynchronous active-low speed-up pushbutton |
| key_slow_n | input | 1 | Asynchronous active-low slow-down pushbutton |
| digits | output | 7*NUM_DIGITS | Active-low segments; digit k at [7k+6:7k], digit 0 rightmost |

## Verification
The checker watches, on every cycle, the properties that involve only neighbouring cycles. The display stays still without a tick. Each tick moves every digit one place left. In ring mode the leftmost digit wraps into digit 0. The rate level stays in range, changes by one step at most, never steps on two consecutive cycles, and moves whenever the count is restarted. Some behaviour shows only over whole intervals and so is left to the bench's scenarios: the exact spacing of shifts at each level, halving and doubling with saturation at both limits, the ignored double press, the three-cycle key latency, the character order during loading, and the rotated text many shifts later.

// File: rtl/ticker_pkg.sv
package ticker_pkg;

  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;

  // active-low segments, bit0 = a ... bit6 = g
  localparam seg_t SEG_BLANK = 7'h7F;
  localparam seg_t SEG_H     = 7'h09;
  localparam seg_t SEG_E     = 7'h06;
  localparam seg_t SEG_L     = 7'h47;
  localparam seg_t SEG_O     = 7'h40;

  typedef enum logic { LD_FILL, LD_RING } load_state_e;
  typedef enum logic { RK_IDLE, RK_WAIT } rate_state_e;

  // character n of the scrolled message; positions past the word are blank
  function automatic seg_t glyph(input int unsigned pos);
    case (pos)
      0:       glyph = SEG_H;
      1:       glyph = SEG_E;
      2, 3:    glyph = SEG_L;
      4:       glyph = SEG_O;
      default: glyph = SEG_BLANK;
    endcase
  endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  output logic pressed
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], key_n};
  end

  assign pressed = ~sync_q[STAGES-1];
endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import ticker_pkg::*;
#(
  parameter int NUM_LEVELS  = 5,
  parameter int RESET_LEVEL = 2,
  parameter int LVL_W       = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_hit,
  input  logic             slow_hit,
  output logic [LVL_W-1:0] level,
  output logic             step
);
  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(NUM_LEVELS - 1);
  localparam logic [LVL_W-1:0] LVL_INIT = LVL_W'(RESET_LEVEL);

  rate_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic             go_faster, go_slower;

  always_comb begin
    go_faster = (state_q == RK_IDLE) && fast_hit && !slow_hit && (level_q != '0);
    go_slower = (state_q == RK_IDLE) && slow_hit && !fast_hit && (level_q != LVL_TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RK_IDLE;
      level_q <= LVL_INIT;
    end else begin
      case (state_q)
        RK_IDLE: if (fast_hit || slow_hit) state_q <= RK_WAIT;
        RK_WAIT: if (!fast_hit && !slow_hit) state_q <= RK_IDLE;
        default: state_q <= RK_IDLE;
      endcase
      if (go_faster)      level_q <= level_q - LVL_W'(1);
      else if (go_slower) level_q <= level_q + LVL_W'(1);
    end
  end

  assign level = level_q;
  assign step  = go_faster | go_slower;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int CYCLES_QUARTER = 12_500_000,
  parameter int NUM_LEVELS     = 5,
  parameter int LVL_W          = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             restart,
  output logic             tick
);
  localparam longint MAX_PERIOD = longint'(CYCLES_QUARTER) << (NUM_LEVELS - 1);
  localparam int     CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(CYCLES_QUARTER) << level;
  assign tick   = (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/text_loader.sv
module text_loader
  import ticker_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  seg_t wrap_seg,
  output seg_t ins_seg,
  output logic ring
);
  load_state_e      state_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    if (state_q == LD_FILL) ins_seg = glyph(int'(idx_q));
    else                    ins_seg = wrap_seg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_FILL;
      idx_q   <= '0;
    end else if (tick && state_q == LD_FILL) begin
      if (idx_q == IDX_W'(NUM_DIGITS - 1)) begin
        state_q <= LD_RING;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign ring = (state_q == LD_RING);
endmodule

// File: rtl/seg_chain.sv
module seg_chain
  import ticker_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  seg_t                        ins_seg,
  output seg_t                        last_seg,
  output logic [NUM_DIGITS*SEG_W-1:0] digits
);
  seg_t stage_q [NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
    seg_t feed;
    if (k == 0) begin : g_head
      assign feed = ins_seg;
    end else begin : g_body
      assign feed = stage_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    stage_q[k] <= SEG_BLANK;
      else if (tick) stage_q[k] <= feed;
    end

    assign digits[k*SEG_W +: SEG_W] = stage_q[k];
  end

  assign last_seg = stage_q[NUM_DIGITS-1];
endmodule

// File: rtl/ticker_scroll.sv
module ticker_scroll
  import ticker_pkg::*;
#(
  parameter int CYCLES_QUARTER = 12_500_000,
  parameter int NUM_DIGITS     = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int NUM_LEVELS     = 5,
  parameter int RESET_LEVEL    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        key_fast_n,
  input  logic                        key_slow_n,
  output logic [NUM_DIGITS*SEG_W-1:0] digits
);
  localparam int LVL_W = $clog2(NUM_LEVELS);

  logic [1:0]       key_raw_n;
  logic [1:0]       key_hit;
  logic [LVL_W-1:0] rate_level;
  logic             rate_step;
  logic             shift_tick;
  logic             ring_mode;
  seg_t             head_seg;
  seg_t             tail_seg;

  assign key_raw_n = {key_slow_n, key_fast_n};

  for (genvar g = 0; g < 2; g++) begin : g_key
    key_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_n   (key_raw_n[g]),
      .pressed (key_hit[g])
    );
  end

  rate_ctrl #(
    .NUM_LEVELS  (NUM_LEVELS),
    .RESET_LEVEL (RESET_LEVEL),
    .LVL_W       (LVL_W)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_hit (key_hit[0]),
    .slow_hit (key_hit[1]),
    .level    (rate_level),
    .step     (rate_step)
  );

  tick_gen #(
    .CYCLES_QUARTER (CYCLES_QUARTER),
    .NUM_LEVELS     (NUM_LEVELS),
    .LVL_W          (LVL_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (rate_level),
    .restart (rate_step),
    .tick    (shift_tick)
  );

  text_loader #(.NUM_DIGITS(NUM_DIGITS)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (shift_tick),
    .wrap_seg (tail_seg),
    .ins_seg  (head_seg),
    .ring     (ring_mode)
  );

  seg_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (shift_tick),
    .ins_seg  (head_seg),
    .last_seg (tail_seg),
    .digits   (digits)
  );
endmodule

// File: rtl/ticker_scroll_chk.sv
module ticker_scroll_chk #(
  parameter int NUM_DIGITS = 8,
  parameter int NUM_LEVELS = 5,
  parameter int LVL_W      = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_DIGITS*7-1:0] digits,
  input logic [LVL_W-1:0]        level,
  input logic                    tick,
  input logic                    ring,
  input logic                    restart
);
  localparam int W = NUM_DIGITS * 7;

  p_reset_blank_r1: assert property (@(posedge clk)
    !rst_n |=> (digits == {NUM_DIGITS{7'h7F}}));

  p_still_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digits));

  p_shift_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (digits[W-1:7] == $past(digits[W-8:0])));

  p_ring_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && tick) |=> (digits[6:0] == $past(digits[W-1:W-7])));

  p_ring_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ring |=> ring);

  p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= NUM_LEVELS - 1);

  p_level_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |->
      ((level == $past(level) + LVL_W'(1)) || (level + LVL_W'(1) == $past(level))));

  p_once_per_press_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |=> $stable(level));

  p_restart_moves_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (level != $past(level)));
endmodule

bind ticker_scroll ticker_scroll_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .NUM_LEVELS (NUM_LEVELS),
  .LVL_W      (LVL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .digits  (digits),
  .level   (rate_level),
  .tick    (shift_tick),
  .ring    (ring_mode),
  .restart (rate_step)
);

// File: tb/ticker_scroll_bench.sv
module ticker_scroll_bench;
  localparam int Q  = 4;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_fast_n = 1'b1;
  logic key_slow_n = 1'b1;
  logic [ND*7-1:0] digits;

  int checks = 0;
  int fails = 0;
  int shifts = 0;
  int since = 0;
  int last_gap = 0;
  logic [ND*7-1:0] prev;

  always #5 clk = ~clk;

  ticker_scroll #(.CYCLES_QUARTER(Q), .NUM_DIGITS(ND)) u_ticker_scroll (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_fast_n (key_fast_n),
    .key_slow_n (key_slow_n),
    .digits     (digits)
  );

  // {fast, slow, hold cycles, expected interval, requirement}
  typedef struct packed {
    logic       f;
    logic       s;
    logic [7:0] hold;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd3,   8'd8,  4'd5},  // R5 halve
    '{1'b1, 1'b0, 8'd40,  8'd4,  4'd7},  // R7 long hold, one step
    '{1'b1, 1'b0, 8'd3,   8'd4,  4'd5},  // R5 floor
    '{1'b1, 1'b1, 8'd5,   8'd4,  4'd8},  // R8 both keys
    '{1'b0, 1'b1, 8'd3,   8'd8,  4'd6},  // R6 double
    '{1'b0, 1'b1, 8'd100, 8'd16, 4'd7},  // R7 long hold, one step
    '{1'b0, 1'b1, 8'd3,   8'd32, 4'd6},  // R6
    '{1'b0, 1'b1, 8'd3,   8'd64, 4'd6},  // R6
    '{1'b0, 1'b1, 8'd3,   8'd64, 4'd6},  // R6 ceiling
    '{1'b1, 1'b1, 8'd5,   8'd64, 4'd8},  // R8 both keys
    '{1'b1, 1'b0, 8'd3,   8'd32, 4'd5}   // R5
  };

  function automatic logic [6:0] msg_char(input int pos);
    case (pos)
      0: msg_char = 7'h09;
      1: msg_char = 7'h06;
      2, 3: msg_char = 7'h47;
      4: msg_char = 7'h40;
      default: msg_char = 7'h7F;
    endcase
  endfunction

  function automatic logic [ND*7-1:0] exp_display(input int n);
    logic [ND*7-1:0] r;
    for (int k = 0; k < ND; k++) begin
      if (n - k < 1) r[k*7 +: 7] = 7'h7F;
      else           r[k*7 +: 7] = msg_char((n - k - 1) % ND);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    since++;
    if (digits !== prev) begin
      shifts++;
      last_gap = since;
      since = 0;
      prev = digits;
    end
  endtask

  task automatic wait_shift();
    int s0;
    int guard;
    s0 = shifts;
    guard = 0;
    while (shifts == s0 && guard < 400) begin
      step();
      guard++;
    end
  endtask

  task automatic press(input logic f, input logic s, input int hold);
    key_fast_n = ~f;
    key_slow_n = ~s;
    repeat (hold) step();
    key_fast_n = 1'b1;
    key_slow_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    prev = {ND{7'h7F}};
    repeat (3) @(negedge clk);
    check(digits == {ND{7'h7F}}, "R1 blank in reset", digits, {ND{7'h7F}});
    rst_n = 1'b1;
    since = 0;

    // loading then ring wrap at the reset rate
    for (int n = 1; n <= 16; n++) begin
      wait_shift();
      if (n <= 8) check(digits == exp_display(shifts), "R3 load display", digits, exp_display(shifts));
      else        check(digits == exp_display(shifts), "R4 ring display", digits, exp_display(shifts));
      check(last_gap == 16, "R2 reset interval", last_gap, 16);
    end

    // rate table
    for (int i = 0; i < NV; i++) begin
      press(VECS[i].f, VECS[i].s, int'(VECS[i].hold));
      wait_shift();
      wait_shift();
      if (last_gap != int'(VECS[i].exp)) begin
        checks++;
        fails++;
        $display("FAIL R%0d rate row %0d actual=%0d expected=%0d", VECS[i].req, i, last_gap, VECS[i].exp);
      end else begin
        checks++;
      end
    end
    check(digits == exp_display(shifts), "R4 ring display after rate changes", digits, exp_display(shifts));

    // R9: key falls right after a shift; latency 3 plus new interval 16
    key_fast_n = 1'b0;
    repeat (3) step();
    key_fast_n = 1'b1;
    wait_shift();
    check(last_gap == 19, "R9 restart latency", last_gap, 19);
    wait_shift();
    check(last_gap == 16, "R9 steady interval", last_gap, 16);

    // R1: reset mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(digits == {ND{7'h7F}}, "R1 blank after reset", digits, {ND{7'h7F}});
    prev = digits;
    shifts = 0;
    since = 0;
    rst_n = 1'b1;
    wait_shift();
    check(last_gap == 16, "R1 rate back to reset level", last_gap, 16);
    check(digits == exp_display(1), "R1 loader restarted", digits, exp_display(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule